// File: doc/BRIEF.md
# Half-Wave Steered Sine PWM Generator

This block drives a full H-bridge with sinusoidal pulse-width modulation. It has two gate-drive outputs, one for each diagonal of the bridge. An 8-bit counter wraps every 256 clocks and sets the carrier rate. A slower update tick walks through a fixed table that holds one half of a sine magnitude. Each step loads the next sample as the duty value of the carrier.

Only one diagonal is modulated at a time. When the table index wraps after a full half-wave, modulation moves to the other output and the idle output is held low. At that boundary the carrier counter restarts at zero, so each half-wave begins on a fresh carrier period.

With the default parameters and an 8 MHz clock, the carrier runs at about 31.25 kHz, the update tick at 10 kHz and the output sine at 50 Hz. An enable input gates the whole block.

Top module: `spwm_bridge_gen`

## Requirements
- R1: While rst_ni is low, both drive outputs are low.
- R2: The carrier counter counts 0 to 255 and wraps, giving a period of 256 clocks. The active output is high while the counter is below the compare value and low otherwise. A compare value of 0 gives a constant low.
- R3: Table entry k, for k = 0 to SAMPLES-1, is floor(AMP × sin(π·k/SAMPLES)). With defaults, entry 0 is 0 and entry 50 is 255. The sample index advances once every PRESCALE × TICK_DIV clocks.
- R4: A new sample is held in a shadow register. It reaches the compare value only when the counter wraps from 255 to 0, so a carrier period never changes duty part-way through.
- R5: When the index wraps from SAMPLES-1 to 0, the active output swaps to the other diagonal. The idle output is always low, and the two outputs are never high together.
- R6: On the tick that wraps the index, the carrier counter is forced to 0 and the compare value takes table entry 0 at once, without waiting for the counter to wrap.
- R7: After reset, and after each re-enable, the first half-wave is driven on drv_a_o, starting from index 0.
- R8: While en_i is low, every counter and the side select are cleared. Both outputs are low from the first clock edge that sees en_i low.
- R9: The outputs are registered. Each one reflects the counter, compare value and side select as they stood before the edge that updates it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable; low holds the block cleared |
| drv_a_o | output | 1 | Gate drive for diagonal A (first half-wave) |
| drv_b_o | output | 1 | Gate drive for diagonal B (second half-wave) |

## Verification
The block is run through more than two half-waves. This covers all of the following:
- duty values from zero up to the 255 peak;
- carrier wraps that coincide with a sample tick, which separates correct double buffering from an early load;
- the boundary tick, which separates a forced counter restart from a free-running carrier.

A mid-run disable followed by a re-enable shows that everything clears and that the next half-wave starts on diagonal A. Every clock is compared against a closed-form timeline derived from the requirements, so a single misplaced edge is enough to be reported.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam real PI_C = 3.14159265358979;

  // floor(amp * sin(pi*k/n)), evaluated at elaboration
  function automatic int half_sine(int k, int n, int amp);
    return $rtoi($floor(amp * $sin(PI_C * k / n)));
  endfunction
endpackage

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
  parameter int SAMPLES = 100,
  parameter int CNT_W   = 8,
  parameter int AMP     = 255,
  localparam int IDX_W  = $clog2(SAMPLES)
) (
  input  logic [IDX_W-1:0] idx_i,
  output logic [CNT_W-1:0] sample_o
);
  logic [CNT_W-1:0] rom [SAMPLES];

  for (genvar g = 0; g < SAMPLES; g++) begin : g_rom
    assign rom[g] = CNT_W'(spwm_pkg::half_sine(g, SAMPLES, AMP));
  end

  assign sample_o = (int'(idx_i) < SAMPLES) ? rom[idx_i] : '0;
endmodule

// File: rtl/spwm_tick_gen.sv
module spwm_tick_gen #(
  parameter int PRESCALE = 4,
  parameter int TICK_DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int PRE_W = $clog2(PRESCALE);
  localparam int DIV_W = $clog2(TICK_DIV);

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] div_q;
  logic pre_wrap, div_wrap;

  assign pre_wrap = (pre_q == PRE_W'(PRESCALE - 1));
  assign div_wrap = (div_q == DIV_W'(TICK_DIV - 1));
  assign tick_o   = en_i && pre_wrap && div_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      div_q <= '0;
    end else if (!en_i) begin
      pre_q <= '0;
      div_q <= '0;
    end else begin
      pre_q <= pre_wrap ? '0 : pre_q + 1'b1;
      if (pre_wrap) div_q <= div_wrap ? '0 : div_q + 1'b1;
    end
  end

  // R3
  div_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(div_q) < TICK_DIV);
endmodule

// File: rtl/spwm_phase_seq.sv
module spwm_phase_seq #(
  parameter int SAMPLES = 100,
  localparam int IDX_W  = $clog2(SAMPLES)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  output logic [IDX_W-1:0] idx_nxt_o,
  output logic             side_o,
  output logic             boundary_o
);
  logic [IDX_W-1:0] idx_q;
  logic             side_q;
  logic             last;

  assign last       = (idx_q == IDX_W'(SAMPLES - 1));
  assign boundary_o = tick_i && last;
  assign idx_nxt_o  = !tick_i ? idx_q : (last ? '0 : idx_q + 1'b1);
  assign side_o     = side_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q  <= '0;
      side_q <= 1'b0;
    end else if (!en_i) begin
      idx_q  <= '0;
      side_q <= 1'b0;
    end else if (tick_i) begin
      idx_q <= idx_nxt_o;
      if (last) side_q <= ~side_q;
    end
  end

  // R3
  idx_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_q) < SAMPLES);
  // R5
  side_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (boundary_o && en_i) |=> (side_q != $past(side_q)));
endmodule

// File: rtl/spwm_pwm_core.sv
module spwm_pwm_core #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] sample_i,
  output logic             hi_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cmp_q, shadow_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_MAX);
  assign hi_o = (cnt_q < cmp_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      cmp_q    <= '0;
      shadow_q <= '0;
    end else if (!en_i) begin
      cnt_q    <= '0;
      cmp_q    <= '0;
      shadow_q <= '0;
    end else begin
      cnt_q <= restart_i ? '0 : cnt_q + 1'b1;
      if (load_i) shadow_q <= sample_i;
      // boundary restart bypasses the shadow
      if (restart_i)  cmp_q <= sample_i;
      else if (wrap)  cmp_q <= shadow_q;
    end
  end

  // R4
  cmp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !wrap && !restart_i) |=> $stable(cmp_q));
  // R6
  restart_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0));
endmodule

// File: rtl/spwm_bridge_gen.sv
module spwm_bridge_gen #(
  parameter int CNT_W    = 8,
  parameter int SAMPLES  = 100,
  parameter int AMP      = 255,
  parameter int PRESCALE = 4,
  parameter int TICK_DIV = 200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic drv_a_o,
  output logic drv_b_o
);
  localparam int IDX_W = $clog2(SAMPLES);

  logic             tick, boundary, side, hi;
  logic [IDX_W-1:0] idx_nxt;
  logic [CNT_W-1:0] sample;

  spwm_tick_gen #(.PRESCALE(PRESCALE), .TICK_DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_o(tick)
  );

  spwm_phase_seq #(.SAMPLES(SAMPLES)) u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .tick_i(tick),
    .idx_nxt_o(idx_nxt), .side_o(side), .boundary_o(boundary)
  );

  spwm_sine_rom #(.SAMPLES(SAMPLES), .CNT_W(CNT_W), .AMP(AMP)) u_rom (
    .idx_i(idx_nxt), .sample_o(sample)
  );

  spwm_pwm_core #(.CNT_W(CNT_W)) u_pwm (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .restart_i(boundary),
    .load_i(tick), .sample_i(sample), .hi_o(hi)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drv_a_o <= 1'b0;
      drv_b_o <= 1'b0;
    end else begin
      drv_a_o <= en_i && !side && hi;
      drv_b_o <= en_i &&  side && hi;
    end
  end

  // R5
  excl_drive_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(drv_a_o && drv_b_o));
  // R5
  idle_a_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    side |=> !drv_a_o);
  // R8
  disable_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!drv_a_o && !drv_b_o));
endmodule

// File: tb/tb_spwm_bridge_gen.sv
module tb_spwm_bridge_gen;
  localparam int PS  = 4;
  localparam int TD  = 128;
  localparam int N   = 100;
  localparam int P   = PS * TD;
  localparam real PI_C = 3.14159265358979;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic en_i = 1'b0;
  logic drv_a_o, drv_b_o;

  int n_chk = 0, n_fail = 0;
  int s = 0;
  bit done = 1'b0;
  int tbl [N];
  logic [1:0] q_val [$];
  string      q_tag [$];

  always #2 clk = ~clk;

  spwm_bridge_gen #(.PRESCALE(PS), .TICK_DIV(TD), .SAMPLES(N)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .en_i(en_i),
    .drv_a_o(drv_a_o), .drv_b_o(drv_b_o)
  );

  // R3: expected table from the stated formula
  initial for (int k = 0; k < N; k++) tbl[k] = $rtoi($floor(255.0 * $sin(PI_C * k / N)));

  // expected outputs after the edge that leaves state st
  task automatic push_expected(input int st, input bit run);
    int k, side, bst, cnt, ps, cmpv;
    bit hi;
    string tag;
    if (!run) begin
      q_val.push_back(2'b00);
      q_tag.push_back(rst_ni ? "R8" : "R1");
      return;
    end
    k    = st / P;
    side = (k / N) % 2;
    bst  = (k / N) * N * P;
    cnt  = (st - bst) % 256;
    ps   = st - cnt;
    // R4: compare comes from the sample held just before the period began
    cmpv = (ps == bst) ? tbl[0] : tbl[((ps - 1) / P) % N];
    hi   = cnt < cmpv;
    if (ps == bst && k > 0) tag = "R6";
    else if (k < N)         tag = "R7 R2 R3 R4 R9";
    else                    tag = "R5 R2 R3 R4 R9";
    q_val.push_back({side == 1 && hi, side == 0 && hi});
    q_tag.push_back(tag);
  endtask

  always @(posedge clk) begin
    if (!rst_ni || !en_i) begin
      push_expected(0, 1'b0);
      s = 0;
    end else begin
      push_expected(s, 1'b1);
      s = s + 1;
    end
  end

  // monitor
  always @(negedge clk) begin
    if (q_val.size() > 0) begin
      logic [1:0] e, o;
      string t;
      e = q_val.pop_front();
      t = q_tag.pop_front();
      o = {drv_b_o, drv_a_o};
      n_chk++;
      if (o != e) begin
        n_fail++;
        if (o == 2'b11 || (o & ~e) != 2'b00 && e != 2'b00) t = "R5";
        $display("FAIL %s at t=%0t: {b,a} actual=%b expected=%b", t, $time, o, e);
      end
    end
  end

  task automatic check_now(input logic [1:0] exp_v, input string tag);
    n_chk++;
    if ({drv_b_o, drv_a_o} != exp_v) begin
      n_fail++;
      $display("FAIL %s: {b,a} actual=%b expected=%b", tag, {drv_b_o, drv_a_o}, exp_v);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #1;
    check_now(2'b00, "R1");
    repeat (5) @(negedge clk);
    check_now(2'b00, "R1");
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check_now(2'b00, "R8");
    en_i = 1'b1;
    // over two half-waves: R2 R3 R4 R5 R6 R7 R9
    repeat (2 * N * P + 7000) @(negedge clk);
    en_i = 1'b0;
    @(negedge clk);
    check_now(2'b00, "R8");
    repeat (4) @(negedge clk);
    check_now(2'b00, "R8");
    en_i = 1'b1;
    // re-enable restarts on diagonal A from index 0: R7
    repeat (3 * P) @(negedge clk);
    @(negedge clk);
    finish_run();
  end

  initial begin
    #(190000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end
endmodule